// File: doc/BRIEF.md
# Synchronous PWM Channel Group Controller

This block runs a set of PWM channel counters, any of which can be joined into one lockstep group. A group member does not use its own prescaler, period and alignment settings. It takes those three settings from channel 0, so every member counts the same sequence on the same clock. Channel 0 is the group's anchor. Starting or stopping channel 0 starts or stops every member at once. Any other member can still be stopped or restarted by itself, and a member restarted while the group runs picks up channel 0's count, so it rejoins in step.

Each channel has a live set of settings, written directly. Members also have a deferred path. Software loads new period, duty and dead-time values into per-channel holding registers, then raises an unlock request. At the next period boundary of channel 0, the held values move into the live settings of every member, and the unlock request clears itself. Each channel drives a high-side and a low-side output, produced by comparing its counter with its duty and dead-time values.

Top module: `pwm_sync_group`

## Requirements
- R1: While reset is high, and on the first cycle after it, all channel enables, membership flags, counters, outputs and the unlock flag are 0.
- R2: A member channel counts with channel 0's prescaler, period and alignment. Writing its own copies of these settings does not change its counter.
- R3: Alignment 0 counts 0 up to the period, then back to 0. Alignment 1 counts up to the period, then down to 0. Each count value holds for prescaler+1 clock cycles.
- R4: Channel 0 is reported and treated as a member whenever any other channel is a member.
- R5: An enable command on channel 0 enables every member. All member counters start at 0 on that cycle and stay identical on every following cycle. A disable command on channel 0 disables every member and clears its counter.
- R6: A member other than channel 0 can be disabled and re-enabled by itself. If it is re-enabled while channel 0 runs, its counter equals channel 0's counter from the first enabled cycle.
- R7: A membership bit is updated only if that channel is disabled when the write occurs. Otherwise the write to that bit is ignored.
- R8: Enable and disable commands on channel 0 do not affect channels that are not members.
- R9: Held period, duty and dead-time values move into the live settings of the members only at a boundary of channel 0's period, and only after unlock has been requested. Non-members keep their live settings.
- R10: The unlock flag reads 1 after an unlock request and returns to 0 by itself when the transfer happens.
- R11: One cycle after an enabled counter value c, the high output is 1 when dead-time ≤ c < duty, and the low output is 1 when c ≥ duty + dead-time. Both outputs are 0 one cycle after the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_cmd | input | NCH | One-cycle enable request per channel; bit 0 starts the group |
| dis_cmd | input | NCH | One-cycle disable request per channel; bit 0 stops the group; wins over enable |
| sync_we | input | 1 | Write strobe for the membership bits |
| sync_wdata | input | NCH | New membership bits (1 = member) |
| cfg_we | input | 1 | Write strobe for a channel's live settings |
| cfg_ch | input | CHW | Channel selected by cfg_we |
| cfg_pre | input | PW | Prescaler: each count holds pre+1 cycles |
| cfg_prd | input | CW | Period (top count) |
| cfg_align | input | 1 | 0 = edge (up, wrap), 1 = center (up, down) |
| cfg_dty | input | CW | Duty compare value |
| cfg_dt | input | CW | Dead-time value |
| upd_we | input | 1 | Write strobe for the holding registers |
| upd_ch | input | CHW | Channel selected by upd_we |
| upd_prd | input | CW | Held period |
| upd_dty | input | CW | Held duty |
| upd_dt | input | CW | Held dead-time |
| unlock_set | input | 1 | Requests a transfer at the next channel 0 boundary |
| ch_en | output | NCH | Channel enable state |
| member | output | NCH | Effective membership, channel 0 included when implied |
| cnt_flat | output | NCH*CW | Counters, channel i at bits i*CW +: CW |
| pwm_h | output | NCH | High-side outputs |
| pwm_l | output | NCH | Low-side outputs |
| unlock | output | 1 | Pending unlock flag |

## Verification
Enable, disable and membership changes show on ch_en and member at the first clock edge after the request, with one register in the path. The counter holds 0 at that edge and starts advancing on the edge after it. The PWM outputs follow the counter by one more register stage. A transfer lands on the edge where channel 0 wraps to 0, and unlock drops on that same edge. The bench therefore drives inputs on falling edges and samples at the next falling edge. It compares each counter sample with a precomputed sequence, checks each output sample against the counter value from the previous sample, and checks deferred updates over windows longer than one full period.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
  typedef enum logic {
    ALIGN_EDGE   = 1'b0,
    ALIGN_CENTER = 1'b1
  } align_e;
endpackage

// File: rtl/pwm_grp_ctrl.sv
// Group membership and enable/disable sequencing.
module pwm_grp_ctrl #(
  parameter int NCH = 4
)(
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] en_cmd,
  input  logic [NCH-1:0] dis_cmd,
  input  logic           sync_we,
  input  logic [NCH-1:0] sync_wdata,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] en_nxt,
  output logic [NCH-1:0] sync_eff,
  output logic [NCH-1:0] clr,
  output logic [NCH-1:0] ld
);
  logic [NCH-1:0] sync_q;
  logic           grp_on, grp_off;

  assign grp_on  = en_cmd[0];
  assign grp_off = dis_cmd[0];

  // channel 0 joins implicitly as soon as any other channel is a member
  always_comb begin
    sync_eff    = sync_q;
    sync_eff[0] = sync_q[0] | (|sync_q[NCH-1:1]);
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (dis_cmd[i] || (grp_off && sync_eff[i]))
        en_nxt[i] = 1'b0;
      else if (en_cmd[i] || (grp_on && sync_eff[i]))
        en_nxt[i] = 1'b1;
      else
        en_nxt[i] = en_q[i];
      // group start from idle: every member restarts from zero together
      clr[i] = en_nxt[i] && sync_eff[i] && grp_on && !en_q[0];
      // late joiner while the group runs: copy channel 0's next state
      ld[i]  = (i != 0) && en_nxt[i] && !en_q[i] && sync_eff[i]
               && en_q[0] && en_nxt[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      sync_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (sync_we) begin
        for (int i = 0; i < NCH; i++)
          if (!en_q[i]) sync_q[i] <= sync_wdata[i];
      end
    end
  end
endmodule

// File: rtl/pwm_grp_regs.sv
// Live settings, holding registers and the unlock/transfer logic.
module pwm_grp_regs #(
  parameter  int NCH = 4,
  parameter  int CW  = 8,
  parameter  int PW  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CHW-1:0]           cfg_ch,
  input  logic [PW-1:0]            cfg_pre,
  input  logic [CW-1:0]            cfg_prd,
  input  logic                     cfg_align,
  input  logic [CW-1:0]            cfg_dty,
  input  logic [CW-1:0]            cfg_dt,
  input  logic                     upd_we,
  input  logic [CHW-1:0]           upd_ch,
  input  logic [CW-1:0]            upd_prd,
  input  logic [CW-1:0]            upd_dty,
  input  logic [CW-1:0]            upd_dt,
  input  logic                     unlock_set,
  input  logic                     boundary,
  input  logic [NCH-1:0]           member,
  output logic [NCH-1:0][PW-1:0]   pre_a,
  output logic [NCH-1:0][CW-1:0]   prd_a,
  output logic [NCH-1:0]           align_a,
  output logic [NCH-1:0][CW-1:0]   dty_a,
  output logic [NCH-1:0][CW-1:0]   dt_a,
  output logic                     unlock_q
);
  logic [NCH-1:0][CW-1:0] hold_prd, hold_dty, hold_dt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_a    <= '0;
      prd_a    <= '0;
      align_a  <= '0;
      dty_a    <= '0;
      dt_a     <= '0;
      hold_prd <= '0;
      hold_dty <= '0;
      hold_dt  <= '0;
      unlock_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        pre_a[cfg_ch]   <= cfg_pre;
        prd_a[cfg_ch]   <= cfg_prd;
        align_a[cfg_ch] <= cfg_align;
        dty_a[cfg_ch]   <= cfg_dty;
        dt_a[cfg_ch]    <= cfg_dt;
      end
      if (upd_we) begin
        hold_prd[upd_ch] <= upd_prd;
        hold_dty[upd_ch] <= upd_dty;
        hold_dt[upd_ch]  <= upd_dt;
      end
      if (unlock_q && boundary) begin
        for (int i = 0; i < NCH; i++) begin
          if (member[i]) begin
            prd_a[i] <= hold_prd[i];
            dty_a[i] <= hold_dty[i];
            dt_a[i]  <= hold_dt[i];
          end
        end
        unlock_q <= 1'b0;
      end
      if (unlock_set) unlock_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan_ctr.sv
// One channel: prescaler, edge/center counter and output compare.
module pwm_chan_ctr
  import pwm_grp_pkg::*;
#(
  parameter int CW = 8,
  parameter int PW = 4
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          en_q,
  input  logic          en_nxt,
  input  logic          clr,
  input  logic          ld,
  input  logic [PW-1:0] ld_pc,
  input  logic [CW-1:0] ld_cnt,
  input  logic          ld_dir,
  input  logic [PW-1:0] pre,
  input  logic [CW-1:0] prd,
  input  align_e        align,
  input  logic [CW-1:0] dty,
  input  logic [CW-1:0] dt,
  output logic [CW-1:0] cnt_q,
  output logic [PW-1:0] nx_pc,
  output logic [CW-1:0] nx_cnt,
  output logic          nx_dir,
  output logic          bnd,
  output logic          pwm_h,
  output logic          pwm_l
);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [PW-1:0] ONE_P = PW'(1);

  logic [PW-1:0] pc_q, adv_pc;
  logic [CW-1:0] adv_cnt;
  logic          dir_q, adv_dir, wrap;   // dir 1 = counting down

  always_comb begin
    adv_pc  = pc_q;
    adv_cnt = cnt_q;
    adv_dir = dir_q;
    wrap    = 1'b0;
    if (en_q) begin
      if (pc_q >= pre) begin
        adv_pc = '0;
        if (align == ALIGN_EDGE) begin
          adv_dir = 1'b0;
          if (cnt_q >= prd) begin
            adv_cnt = '0;
            wrap    = 1'b1;
          end else begin
            adv_cnt = cnt_q + ONE_C;
          end
        end else if (dir_q || (cnt_q >= prd)) begin
          if (cnt_q <= ONE_C) begin
            adv_cnt = '0;
            adv_dir = 1'b0;
            wrap    = 1'b1;
          end else begin
            adv_cnt = cnt_q - ONE_C;
            adv_dir = 1'b1;
          end
        end else begin
          adv_cnt = cnt_q + ONE_C;
        end
      end else begin
        adv_pc = pc_q + ONE_P;
      end
    end
  end

  always_comb begin
    if (!en_nxt || clr) begin
      nx_pc  = '0;
      nx_cnt = '0;
      nx_dir = 1'b0;
    end else if (ld) begin
      nx_pc  = ld_pc;
      nx_cnt = ld_cnt;
      nx_dir = ld_dir;
    end else begin
      nx_pc  = adv_pc;
      nx_cnt = adv_cnt;
      nx_dir = adv_dir;
    end
  end

  assign bnd = wrap && en_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
      pwm_h <= 1'b0;
      pwm_l <= 1'b0;
    end else begin
      pc_q  <= nx_pc;
      cnt_q <= nx_cnt;
      dir_q <= nx_dir;
      pwm_h <= en_q && (cnt_q >= dt) && (cnt_q < dty);
      pwm_l <= en_q && ({1'b0, cnt_q} >= ({1'b0, dty} + {1'b0, dt}));
    end
  end
endmodule

// File: rtl/pwm_sync_group.sv
module pwm_sync_group
  import pwm_grp_pkg::*;
#(
  parameter  int NCH = 4,
  parameter  int CW  = 8,
  parameter  int PW  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    en_cmd,
  input  logic [NCH-1:0]    dis_cmd,
  input  logic              sync_we,
  input  logic [NCH-1:0]    sync_wdata,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [PW-1:0]     cfg_pre,
  input  logic [CW-1:0]     cfg_prd,
  input  logic              cfg_align,
  input  logic [CW-1:0]     cfg_dty,
  input  logic [CW-1:0]     cfg_dt,
  input  logic              upd_we,
  input  logic [CHW-1:0]    upd_ch,
  input  logic [CW-1:0]     upd_prd,
  input  logic [CW-1:0]     upd_dty,
  input  logic [CW-1:0]     upd_dt,
  input  logic              unlock_set,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    member,
  output logic [NCH*CW-1:0] cnt_flat,
  output logic [NCH-1:0]    pwm_h,
  output logic [NCH-1:0]    pwm_l,
  output logic              unlock
);
  logic [NCH-1:0]          en_q, en_nxt, sync_eff, clr, ld, bnd;
  logic [NCH-1:0][PW-1:0]  pre_a, nx_pc;
  logic [NCH-1:0][CW-1:0]  prd_a, dty_a, dt_a, cnt_a, nx_cnt;
  logic [NCH-1:0]          align_a, nx_dir;
  logic                    unlock_q;

  pwm_grp_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst(rst), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .sync_we(sync_we), .sync_wdata(sync_wdata),
    .en_q(en_q), .en_nxt(en_nxt), .sync_eff(sync_eff), .clr(clr), .ld(ld)
  );

  pwm_grp_regs #(.NCH(NCH), .CW(CW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_pre(cfg_pre), .cfg_prd(cfg_prd),
    .cfg_align(cfg_align), .cfg_dty(cfg_dty), .cfg_dt(cfg_dt),
    .upd_we(upd_we), .upd_ch(upd_ch), .upd_prd(upd_prd), .upd_dty(upd_dty),
    .upd_dt(upd_dt), .unlock_set(unlock_set), .boundary(bnd[0]),
    .member(sync_eff),
    .pre_a(pre_a), .prd_a(prd_a), .align_a(align_a), .dty_a(dty_a),
    .dt_a(dt_a), .unlock_q(unlock_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [PW-1:0] pre_e;
    logic [CW-1:0] prd_e;
    align_e        align_e_sel;

    // members take channel 0's timing fields instead of their own
    assign pre_e       = sync_eff[i] ? pre_a[0] : pre_a[i];
    assign prd_e       = sync_eff[i] ? prd_a[0] : prd_a[i];
    assign align_e_sel = align_e'(sync_eff[i] ? align_a[0] : align_a[i]);

    pwm_chan_ctr #(.CW(CW), .PW(PW)) u_ctr (
      .clk(clk), .rst(rst), .en_q(en_q[i]), .en_nxt(en_nxt[i]),
      .clr(clr[i]), .ld(ld[i]),
      .ld_pc(nx_pc[0]), .ld_cnt(nx_cnt[0]), .ld_dir(nx_dir[0]),
      .pre(pre_e), .prd(prd_e), .align(align_e_sel),
      .dty(dty_a[i]), .dt(dt_a[i]),
      .cnt_q(cnt_a[i]), .nx_pc(nx_pc[i]), .nx_cnt(nx_cnt[i]),
      .nx_dir(nx_dir[i]), .bnd(bnd[i]),
      .pwm_h(pwm_h[i]), .pwm_l(pwm_l[i])
    );

    assign cnt_flat[i*CW +: CW] = cnt_a[i];
  end

  // next-state taps of channels 1..NCH-1 have no reader
  logic unused_taps;
  assign unused_taps = ^{bnd[NCH-1:1], nx_pc[NCH-1:1], nx_cnt[NCH-1:1],
                         nx_dir[NCH-1:1]};

  assign ch_en  = en_q;
  assign member = sync_eff;
  assign unlock = unlock_q;
endmodule

// File: rtl/pwm_sync_group_chk.sv
module pwm_sync_group_chk #(
  parameter int NCH = 4,
  parameter int CW  = 8
)(
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    member,
  input logic [NCH*CW-1:0] cnt_flat,
  input logic [NCH-1:0]    pwm_h,
  input logic [NCH-1:0]    pwm_l,
  input logic              unlock
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch_en == '0 && !unlock));

  for (genvar i = 1; i < NCH; i++) begin : g_mem
    a_r5_lockstep: assert property (@(posedge clk) disable iff (rst)
      (ch_en[0] && ch_en[i] && member[i]) |->
        (cnt_flat[i*CW +: CW] == cnt_flat[CW-1:0]));

    a_r7_sync_hold: assert property (@(posedge clk) disable iff (rst)
      $past(ch_en[i]) |-> (member[i] == $past(member[i])));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_out
    a_r11_quiet_off: assert property (@(posedge clk) disable iff (rst)
      !$past(ch_en[i]) |-> (!pwm_h[i] && !pwm_l[i]));
  end
endmodule

bind pwm_sync_group pwm_sync_group_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ch_en(ch_en), .member(member),
  .cnt_flat(cnt_flat), .pwm_h(pwm_h), .pwm_l(pwm_l), .unlock(unlock)
);

// File: tb/pwm_sync_group_bench.sv
`timescale 1ns/1ps
module pwm_sync_group_bench;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int PW  = 4;

  // {pre[44:41], prd[40:33], align[32], eight 4-bit expected counts}
  localparam logic [44:0] TBL [4] = '{
    {4'd0, 8'd3, 1'b0, 32'h0123_0123},
    {4'd0, 8'd3, 1'b1, 32'h0123_2101},
    {4'd1, 8'd2, 1'b0, 32'h0011_2200},
    {4'd0, 8'd2, 1'b1, 32'h0121_0121}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NCH-1:0]    en_cmd = '0, dis_cmd = '0, sync_wdata = '0;
  logic              sync_we = 0, cfg_we = 0, cfg_align = 0, upd_we = 0, unlock_set = 0;
  logic [1:0]        cfg_ch = '0, upd_ch = '0;
  logic [PW-1:0]     cfg_pre = '0;
  logic [CW-1:0]     cfg_prd = '0, cfg_dty = '0, cfg_dt = '0;
  logic [CW-1:0]     upd_prd = '0, upd_dty = '0, upd_dt = '0;
  logic [NCH-1:0]    ch_en, member, pwm_h, pwm_l;
  logic [NCH*CW-1:0] cnt_flat;
  logic              unlock;

  pwm_sync_group #(.NCH(NCH), .CW(CW), .PW(PW)) u_pwm_sync_group (
    .clk(clk), .rst(rst), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .sync_we(sync_we), .sync_wdata(sync_wdata),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_pre(cfg_pre), .cfg_prd(cfg_prd),
    .cfg_align(cfg_align), .cfg_dty(cfg_dty), .cfg_dt(cfg_dt),
    .upd_we(upd_we), .upd_ch(upd_ch), .upd_prd(upd_prd), .upd_dty(upd_dty),
    .upd_dt(upd_dt), .unlock_set(unlock_set),
    .ch_en(ch_en), .member(member), .cnt_flat(cnt_flat),
    .pwm_h(pwm_h), .pwm_l(pwm_l), .unlock(unlock)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cnt(input int i);
    return int'(cnt_flat[i*CW +: CW]);
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic pulse_en(input logic [NCH-1:0] m);
    en_cmd = m; step(); en_cmd = '0;
  endtask

  task automatic pulse_dis(input logic [NCH-1:0] m);
    dis_cmd = m; step(); dis_cmd = '0;
  endtask

  task automatic set_sync(input logic [NCH-1:0] m);
    sync_we = 1; sync_wdata = m; step(); sync_we = 0;
  endtask

  task automatic cfg(input int ch, input int pre, input int prd, input logic al,
                     input int dty, input int dt);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_pre = PW'(pre); cfg_prd = CW'(prd);
    cfg_align = al; cfg_dty = CW'(dty); cfg_dt = CW'(dt);
    step(); cfg_we = 0;
  endtask

  task automatic upd(input int ch, input int prd, input int dty, input int dt);
    upd_we = 1; upd_ch = 2'(ch); upd_prd = CW'(prd); upd_dty = CW'(dty); upd_dt = CW'(dt);
    step(); upd_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int mx, mx3, prev_c, prev_e, bad_h, bad_l, same;
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    check("R1 ch_en", int'(ch_en), 0);
    check("R1 member", int'(member), 0);
    check("R1 counters", int'(cnt_flat), 0);
    check("R1 outputs", int'({pwm_h, pwm_l}), 0);
    check("R1 unlock", int'(unlock), 0);

    // table walk: group of ch1, ch2 (ch0 implied) under several ch0 timings
    for (int r = 0; r < 4; r++) begin
      logic [3:0]  pre;
      logic [7:0]  prd;
      logic        al;
      logic [31:0] seq;
      pre = TBL[r][44:41]; prd = TBL[r][40:33]; al = TBL[r][32]; seq = TBL[r][31:0];
      pulse_dis(4'b1111);
      set_sync(4'b0110);
      cfg(0, int'(pre), int'(prd), al, 2, 0);
      cfg(1, 2, 9, ~al, 1, 0);
      cfg(2, 3, 6, ~al, 3, 0);
      pulse_en(4'b0001);
      same = 1;
      for (int k = 0; k < 8; k++) begin
        check($sformatf("R3 row%0d step%0d cnt0", r, k), cnt(0), int'(seq[31-4*k -: 4]));
        if (cnt(1) != cnt(0) || cnt(2) != cnt(0)) same = 0;
        if (k < 7) step();
      end
      check($sformatf("R5 R2 row%0d members identical", r), same, 1);
      check($sformatf("R5 R8 row%0d ch_en", r), int'(ch_en), 4'b0111);
      check($sformatf("R4 row%0d member", r), int'(member), 4'b0111);
    end

    // R7: clearing membership of enabled channels is ignored
    set_sync(4'b0000);
    check("R7 enabled bits kept", int'(member), 4'b0111);

    // R8: non-member ch3 runs on its own settings
    cfg(3, 0, 5, 1'b0, 0, 0);
    pulse_en(4'b1000);
    for (int k = 0; k < 6; k++) begin
      check($sformatf("R8 ch3 own count %0d", k), cnt(3), k);
      step();
    end
    set_sync(4'b1000);
    check("R7 ch3 enabled, bit ignored", int'(member[3]), 0);
    pulse_dis(4'b0001);
    check("R5 R8 group stop leaves ch3", int'(ch_en), 4'b1000);
    check("R5 stopped counters", cnt(0) + cnt(1) + cnt(2), 0);
    pulse_en(4'b0001);
    check("R5 R8 group restart", int'(ch_en), 4'b1111);

    // R6: individual stop and rejoin of ch1
    repeat (3) step();
    pulse_dis(4'b0010);
    check("R6 ch1 alone stopped", int'(ch_en), 4'b1101);
    repeat (2) step();
    pulse_en(4'b0010);
    check("R6 ch1 back", int'(ch_en), 4'b1111);
    same = 1;
    for (int k = 0; k < 6; k++) begin
      if (cnt(1) != cnt(0)) same = 0;
      step();
    end
    check("R6 rejoined ch1 in step", same, 1);

    // R2: own timing write on a running member has no effect
    cfg(1, 0, 1, 1'b0, 1, 0);
    same = 1;
    for (int k = 0; k < 8; k++) begin
      if (cnt(1) != cnt(0)) same = 0;
      step();
    end
    check("R2 own fields ignored", same, 1);

    // R9 / R10: deferred update
    pulse_dis(4'b0001);
    cfg(0, 0, 3, 1'b0, 2, 1);
    cfg(1, 0, 3, 1'b0, 1, 0);
    pulse_en(4'b0001);
    upd(0, 5, 4, 1);
    upd(1, 7, 3, 0);
    mx = 0;
    for (int k = 0; k < 10; k++) begin
      if (cnt(0) > mx) mx = cnt(0);
      step();
    end
    check("R9 no transfer without unlock", mx, 3);
    unlock_set = 1; step(); unlock_set = 0;
    check("R10 unlock pending", int'(unlock), 1);
    mx = 0;
    for (int k = 0; k < 12; k++) begin
      if (cnt(0) > mx) mx = cnt(0);
      step();
    end
    check("R9 new period active", mx, 5);
    check("R10 unlock self-cleared", int'(unlock), 0);
    mx3 = 0;
    for (int k = 0; k < 8; k++) begin
      if (cnt(3) > mx3) mx3 = cnt(3);
      step();
    end
    check("R9 non-member ch3 period kept", mx3, 5);

    // R11: outputs vs previous counter, ch0 duty 4 dead-time 1
    bad_h = 0; bad_l = 0;
    prev_c = cnt(0); prev_e = int'(ch_en[0]);
    for (int k = 0; k < 12; k++) begin
      step();
      if (int'(pwm_h[0]) != int'(prev_e == 1 && prev_c >= 1 && prev_c < 4)) bad_h++;
      if (int'(pwm_l[0]) != int'(prev_e == 1 && prev_c >= 5)) bad_l++;
      prev_c = cnt(0); prev_e = int'(ch_en[0]);
    end
    check("R11 high-side mismatches", bad_h, 0);
    check("R11 low-side mismatches", bad_l, 0);
    pulse_dis(4'b1111);
    step();
    check("R11 quiet after disable", int'({pwm_h, pwm_l}), 0);

    // R4 / R7: membership accepted when disabled, ch0 implied
    set_sync(4'b0100);
    check("R4 ch0 implied", int'(member), 4'b0101);
    set_sync(4'b0000);
    check("R4 R7 cleared when idle", int'(member), 0);

    // R1: reset during operation
    set_sync(4'b0010);
    pulse_en(4'b0001);
    unlock_set = 1; step(); unlock_set = 0;
    rst = 1; step(); rst = 0;
    check("R1 mid-run reset ch_en", int'(ch_en), 0);
    check("R1 mid-run reset unlock", int'(unlock), 0);
    check("R1 mid-run reset member", int'(member), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule